// File: doc/BRIEF.md
# Multithreaded Decode Stall Controller

This block steers instructions through the decode stage of a superscalar, multithreaded core. Every cycle it takes a fetch bundle of up to `FW` slots, each slot carrying a valid bit, a thread tag, a "killed" mark and a payload. It forwards at most `DW` live instructions to rename and keeps each thread's ordering intact while rename, execute or commit hold that thread back. Each thread owns a skid queue of `FETCH_DLY*FW + DW` entries. That is enough to absorb the instructions still in flight from fetch after the thread asks fetch to hold.

Each thread runs its own five-state machine. IDLE is the state after reset. RUN sends instructions straight through. BLOCKED holds everything in the skid queue. UNBLOCK drains the skid queue ahead of newer arrivals. SQUASH is entered on a commit flush. The transitions are named: ARRIVE (IDLE to RUN), STALL (any state to BLOCKED), OVERRUN (RUN to BLOCKED when the slots run out), RELEASE (BLOCKED to UNBLOCK or RUN), DRAINED (UNBLOCK to RUN), FLUSH and HOLD (any state to SQUASH), and RESUME (SQUASH to RUN). Toward fetch the block raises one-cycle `fe_block` and `fe_unblock` pulses per thread. On a flush it reports how many of the thread's incoming slots were discarded. `stage_active` tells the core that some thread is still draining its skid queue.

Top module: `decode_stall_ctl`

## Requirements
- R1: After reset every thread is in IDLE with all three stall flags clear and an empty skid queue. No rename slot is valid, no fetch pulse is raised, and `stage_active` is low.
- R2: Each downstream source (rename, execute, commit) keeps a sticky per-thread flag. A set pulse raises it and a clear pulse lowers it, and the clear pulse wins when both arrive together. The flags take effect in the same cycle, and the thread is stalled while any of its flags is set.
- R3: A stalled thread (with no flush or hold) goes to BLOCKED and sends nothing. Its live incoming instructions are appended to its skid queue in slot order. `fe_block` pulses for that thread unless it was already BLOCKED.
- R4: At most `DW` instructions go to rename per cycle, shared among threads. Threads are served from thread 0 upward, each sends oldest first, and valid rename slots are packed from slot 0 with `ren_tid` naming the thread. A thread in IDLE, RUN or SQUASH that is left with unsent instructions moves them to its skid queue, goes to BLOCKED and pulses `fe_block`.
- R5: An unstalled thread in BLOCKED or UNBLOCK sends from its skid queue first, followed by newly arrived instructions. Whatever does not fit stays queued in UNBLOCK. Once nothing remains it pulses `fe_unblock` and goes to RUN.
- R6: `cmt_squash` for a thread has top priority. The thread goes to SQUASH with an empty skid queue and drops all of its incoming slots. In that cycle `sq_count` for the thread equals the number of valid fetch slots tagged with it, killed ones included; in every other cycle it is 0.
- R7: A flush that hits a thread in BLOCKED or UNBLOCK pulses `fe_unblock`. The exception is a thread in UNBLOCK that is stalled in that same cycle: the block it would have raised is cancelled and neither pulse is sent.
- R8: `cmt_rob_busy` without a flush puts the thread in SQUASH. The thread sends nothing, its incoming slots are dropped, and its skid queue is kept.
- R9: A thread in SQUASH with no flush, hold or stall resumes through RUN behaviour in that cycle. A thread in IDLE moves to RUN as soon as it has any live instruction.
- R10: Slots marked killed are dropped on arrival. They use no rename slot and no skid entry.
- R11: `stage_active` is high exactly when at least one thread is currently in UNBLOCK.
- R12: The skid queue depth is `FETCH_DLY*FW + DW` (6 with the defaults), and a fetch unit that obeys `fe_block` never overfills it. The bench fills one thread's queue to exactly that depth and drains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_vld | input | FW | Fetch slot valid |
| fe_tid | input | FW x TW | Thread tag per fetch slot |
| fe_kill | input | FW | Slot already marked squashed |
| fe_data | input | FW x PW | Instruction payload per slot |
| ren_stall_set | input | NT | Rename stall set pulse per thread |
| ren_stall_clr | input | NT | Rename stall clear pulse per thread |
| ex_stall_set | input | NT | Execute stall set pulse per thread |
| ex_stall_clr | input | NT | Execute stall clear pulse per thread |
| cmt_stall_set | input | NT | Commit stall set pulse per thread |
| cmt_stall_clr | input | NT | Commit stall clear pulse per thread |
| cmt_squash | input | NT | Commit flush per thread |
| cmt_rob_busy | input | NT | Commit still flushing per thread |
| ren_vld | output | DW | Rename slot valid, packed from slot 0 |
| ren_tid | output | DW x TW | Thread tag per rename slot |
| ren_data | output | DW x PW | Payload per rename slot |
| fe_block | output | NT | Hold request pulse to fetch |
| fe_unblock | output | NT | Release pulse to fetch |
| sq_count | output | NT x CW | Slots discarded by a flush this cycle |
| stage_active | output | 1 | Some thread is in UNBLOCK |

## Verification
The risk is a wrong thread state or a skid queue that holds the wrong contents. Both tend to stay hidden until the thread is released. A stale BLOCKED state shows up in the same cycle as a missing or repeated `fe_block`. A miscounted or misordered skid queue only appears once the thread drains, as wrong payloads or a shifted `ren_vld` pattern, one to three cycles later. The bench therefore runs a behavioural model of every thread in step with the design. It compares every rename slot, every fetch pulse, `sq_count` and `stage_active` on every cycle, so the first divergence is reported in the cycle where it reaches a port.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    // Per-thread status of the decode stage
    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_RUN     = 3'd1,
        TS_BLOCKED = 3'd2,
        TS_UNBLOCK = 3'd3,
        TS_SQUASH  = 3'd4
    } thr_state_t;

    // Entries needed to absorb in-flight fetch traffic plus one decode group
    function automatic int skid_depth(input int fetch_dly, input int fetch_w, input int dec_w);
        return fetch_dly * fetch_w + dec_w;
    endfunction

endpackage

// File: rtl/dcs_stall_track.sv
// Sticky per-thread stall flags, one bank per downstream source.
module dcs_stall_track #(
    parameter int NT   = 2,
    parameter int NSRC = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0][NT-1:0]   set_p,
    input  logic [NSRC-1:0][NT-1:0]   clr_p,
    output logic [NT-1:0]             stalled
);

    logic [NSRC-1:0][NT-1:0] flag_q;
    logic [NSRC-1:0][NT-1:0] flag_d;

    // clear pulse dominates a coincident set pulse
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign flag_d[g] = (flag_q[g] | set_p[g]) & ~clr_p[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // updated flags act in the current cycle
    always_comb begin
        stalled = '0;
        for (int g = 0; g < NSRC; g++) stalled = stalled | flag_d[g];
    end

endmodule

// File: rtl/dcs_thread_lane.sv
// One thread: status machine plus its skid queue.
module dcs_thread_lane
    import dcs_pkg::*;
#(
    parameter int NT    = 2,
    parameter int FW    = 2,
    parameter int DW    = 2,
    parameter int PW    = 8,
    parameter int DEPTH = 6,
    parameter int TID   = 0,
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
    localparam int FCW  = $clog2(DW + 1),
    localparam int SCW  = $clog2(DEPTH + 1),
    localparam int CW   = $clog2(FW + 1),
    localparam int TOT  = DEPTH + FW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FW-1:0]           fe_vld,
    input  logic [FW-1:0][TW-1:0]   fe_tid,
    input  logic [FW-1:0]           fe_kill,
    input  logic [FW-1:0][PW-1:0]   fe_data,
    input  logic                    squash,
    input  logic                    rob_busy,
    input  logic                    stalled,
    input  logic [FCW-1:0]          free_in,
    output logic [FCW-1:0]          sent_n,
    output logic [DW-1:0][PW-1:0]   sent_data,
    output logic                    blk_pulse,
    output logic                    unb_pulse,
    output logic [CW-1:0]           sq_cnt,
    output thr_state_t              st_out,
    output logic [SCW-1:0]          cnt_out,
    output logic                    ovf
);

    thr_state_t        st_q, st_d;
    logic [SCW-1:0]    cnt_q, cnt_d;
    logic [PW-1:0]     skid_q [DEPTH];
    logic [PW-1:0]     skid_d [DEPTH];
    logic [PW-1:0]     in_items [FW];
    logic [PW-1:0]     comb_q [TOT];

    int n_in, n_all, sk_n, tot, k, take, len, send;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TS_IDLE;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) skid_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) skid_q[i] <= skid_d[i];
        end
    end

    // next-state and output process
    always_comb begin
        n_in  = 0;
        n_all = 0;
        for (int s = 0; s < FW; s++) in_items[s] = '0;
        for (int s = 0; s < FW; s++) begin
            if (fe_vld[s] && fe_tid[s] == TW'(TID)) begin
                n_all = n_all + 1;
                if (!fe_kill[s]) begin
                    in_items[n_in] = fe_data[s];
                    n_in = n_in + 1;
                end
            end
        end

        // work queue: skid entries, then fresh arrivals
        sk_n = int'(cnt_q);
        for (int i = 0; i < TOT; i++) comb_q[i] = '0;
        for (int i = 0; i < DEPTH; i++) if (i < sk_n) comb_q[i] = skid_q[i];
        for (int s = 0; s < FW; s++) if (s < n_in) comb_q[sk_n + s] = in_items[s];
        tot = sk_n + n_in;
        k   = (int'(free_in) < tot) ? int'(free_in) : tot;

        st_d      = st_q;
        send      = 0;
        take      = 0;
        len       = sk_n;
        blk_pulse = 1'b0;
        unb_pulse = 1'b0;

        if (squash) begin
            // FLUSH
            st_d = TS_SQUASH;
            len  = 0;
            if (st_q == TS_BLOCKED || st_q == TS_UNBLOCK)
                unb_pulse = !(stalled && st_q == TS_UNBLOCK);
        end else if (rob_busy) begin
            // HOLD
            st_d = TS_SQUASH;
        end else if (stalled) begin
            // STALL
            st_d      = TS_BLOCKED;
            len       = tot;
            blk_pulse = (st_q != TS_BLOCKED);
        end else begin
            send = k;
            take = k;
            len  = tot - k;
            unique case (st_q)
                TS_BLOCKED, TS_UNBLOCK: begin
                    // RELEASE / DRAINED
                    if (len == 0) begin
                        st_d      = TS_RUN;
                        unb_pulse = 1'b1;
                    end else begin
                        st_d = TS_UNBLOCK;
                    end
                end
                TS_IDLE, TS_RUN, TS_SQUASH: begin
                    if (len > 0) begin
                        // OVERRUN
                        st_d      = TS_BLOCKED;
                        blk_pulse = 1'b1;
                    end else if (st_q == TS_IDLE && tot == 0) begin
                        st_d = TS_IDLE;
                    end else begin
                        // ARRIVE / RESUME
                        st_d = TS_RUN;
                    end
                end
            endcase
        end

        for (int i = 0; i < DEPTH; i++) begin
            skid_d[i] = '0;
            if (i + take < TOT) skid_d[i] = comb_q[i + take];
        end
        ovf   = (len > DEPTH);
        cnt_d = SCW'((len > DEPTH) ? DEPTH : len);

        for (int j = 0; j < DW; j++) sent_data[j] = (j < send) ? comb_q[j] : '0;
        sent_n  = FCW'(send);
        sq_cnt  = squash ? CW'(n_all) : '0;
        st_out  = st_q;
        cnt_out = cnt_q;
    end

endmodule

// File: rtl/dcs_issue_pack.sv
// Packs per-thread send lists into rename slots, thread 0 first.
module dcs_issue_pack #(
    parameter int NT  = 2,
    parameter int DW  = 2,
    parameter int PW  = 8,
    localparam int TW  = (NT > 1) ? $clog2(NT) : 1,
    localparam int FCW = $clog2(DW + 1)
) (
    input  logic [NT-1:0][FCW-1:0]          cnt,
    input  logic [NT-1:0][DW-1:0][PW-1:0]   data,
    output logic [DW-1:0]                   vld_o,
    output logic [DW-1:0][TW-1:0]           tid_o,
    output logic [DW-1:0][PW-1:0]           data_o
);

    int base;

    always_comb begin
        vld_o  = '0;
        tid_o  = '0;
        data_o = '0;
        base   = 0;
        for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < DW; j++) begin
                if (j < int'(cnt[t]) && base + j < DW) begin
                    vld_o[base + j]  = 1'b1;
                    tid_o[base + j]  = TW'(t);
                    data_o[base + j] = data[t][j];
                end
            end
            base = base + int'(cnt[t]);
        end
    end

endmodule

// File: rtl/decode_stall_ctl.sv
module decode_stall_ctl
    import dcs_pkg::*;
#(
    parameter int NT        = 2,
    parameter int FW        = 2,
    parameter int DW        = 2,
    parameter int PW        = 8,
    parameter int FETCH_DLY = 2,
    localparam int TW    = (NT > 1) ? $clog2(NT) : 1,
    localparam int DEPTH = skid_depth(FETCH_DLY, FW, DW),
    localparam int FCW   = $clog2(DW + 1),
    localparam int SCW   = $clog2(DEPTH + 1),
    localparam int CW    = $clog2(FW + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FW-1:0]           fe_vld,
    input  logic [FW-1:0][TW-1:0]   fe_tid,
    input  logic [FW-1:0]           fe_kill,
    input  logic [FW-1:0][PW-1:0]   fe_data,
    input  logic [NT-1:0]           ren_stall_set,
    input  logic [NT-1:0]           ren_stall_clr,
    input  logic [NT-1:0]           ex_stall_set,
    input  logic [NT-1:0]           ex_stall_clr,
    input  logic [NT-1:0]           cmt_stall_set,
    input  logic [NT-1:0]           cmt_stall_clr,
    input  logic [NT-1:0]           cmt_squash,
    input  logic [NT-1:0]           cmt_rob_busy,
    output logic [DW-1:0]           ren_vld,
    output logic [DW-1:0][TW-1:0]   ren_tid,
    output logic [DW-1:0][PW-1:0]   ren_data,
    output logic [NT-1:0]           fe_block,
    output logic [NT-1:0]           fe_unblock,
    output logic [NT-1:0][CW-1:0]   sq_count,
    output logic                    stage_active
);

    logic [NT-1:0]                  stalled;
    logic [NT:0][FCW-1:0]           free_c;
    logic [NT-1:0][FCW-1:0]         sent_n;
    logic [NT-1:0][DW-1:0][PW-1:0]  sent_d;
    thr_state_t [NT-1:0]            lane_st;
    logic [NT-1:0][SCW-1:0]         lane_cnt;
    logic [NT-1:0]                  lane_ovf;

    dcs_stall_track #(.NT(NT), .NSRC(3)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_p   ({cmt_stall_set, ex_stall_set, ren_stall_set}),
        .clr_p   ({cmt_stall_clr, ex_stall_clr, ren_stall_clr}),
        .stalled (stalled)
    );

    assign free_c[0] = FCW'(DW);

    for (genvar t = 0; t < NT; t++) begin : g_lane
        dcs_thread_lane #(
            .NT(NT), .FW(FW), .DW(DW), .PW(PW), .DEPTH(DEPTH), .TID(t)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .fe_vld    (fe_vld),
            .fe_tid    (fe_tid),
            .fe_kill   (fe_kill),
            .fe_data   (fe_data),
            .squash    (cmt_squash[t]),
            .rob_busy  (cmt_rob_busy[t]),
            .stalled   (stalled[t]),
            .free_in   (free_c[t]),
            .sent_n    (sent_n[t]),
            .sent_data (sent_d[t]),
            .blk_pulse (fe_block[t]),
            .unb_pulse (fe_unblock[t]),
            .sq_cnt    (sq_count[t]),
            .st_out    (lane_st[t]),
            .cnt_out   (lane_cnt[t]),
            .ovf       (lane_ovf[t])
        );
        assign free_c[t+1] = free_c[t] - sent_n[t];
    end

    dcs_issue_pack #(.NT(NT), .DW(DW), .PW(PW)) u_pack (
        .cnt    (sent_n),
        .data   (sent_d),
        .vld_o  (ren_vld),
        .tid_o  (ren_tid),
        .data_o (ren_data)
    );

    always_comb begin
        stage_active = 1'b0;
        for (int t = 0; t < NT; t++)
            if (lane_st[t] == TS_UNBLOCK) stage_active = 1'b1;
    end

endmodule

// File: rtl/dcs_chk.sv
module dcs_chk
    import dcs_pkg::*;
#(
    parameter int NT    = 2,
    parameter int DW    = 2,
    parameter int DEPTH = 6,
    localparam int SCW  = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [DW-1:0]           ren_vld,
    input logic [NT-1:0]           fe_block,
    input logic [NT-1:0]           fe_unblock,
    input logic [NT-1:0]           cmt_squash,
    input logic [NT-1:0]           cmt_rob_busy,
    input thr_state_t [NT-1:0]     lane_st,
    input logic [NT-1:0][SCW-1:0]  lane_cnt,
    input logic [NT-1:0]           lane_ovf
);

    // R4
    pack_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ren_vld + DW'(1)) & ren_vld) == '0);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // R7
        pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(fe_block[t] && fe_unblock[t]));

        // R3
        block_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fe_block[t] |=> lane_st[t] == TS_BLOCKED);

        // R5
        unblock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fe_unblock[t] && !cmt_squash[t]) |=> lane_st[t] == TS_RUN);

        // R6
        squash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmt_squash[t] |=> (lane_st[t] == TS_SQUASH && lane_cnt[t] == '0));

        // R8
        rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmt_rob_busy[t] && !cmt_squash[t]) |=> (lane_st[t] == TS_SQUASH && $stable(lane_cnt[t])));

        // R12
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_ovf[t] && lane_cnt[t] <= SCW'(DEPTH));
    end

endmodule

bind decode_stall_ctl dcs_chk #(.NT(NT), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_vld      (ren_vld),
    .fe_block     (fe_block),
    .fe_unblock   (fe_unblock),
    .cmt_squash   (cmt_squash),
    .cmt_rob_busy (cmt_rob_busy),
    .lane_st      (lane_st),
    .lane_cnt     (lane_cnt),
    .lane_ovf     (lane_ovf)
);

// File: tb/decode_stall_ctl_test.sv
`timescale 1ns/1ps
module decode_stall_ctl_test;

    localparam int NT = 2, FW = 2, DW = 2, PW = 8, FD = 2;
    localparam int TW = 1, CW = 2;
    localparam int DEPTH = FD * FW + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [FW-1:0]         fe_vld;
    logic [FW-1:0][TW-1:0] fe_tid;
    logic [FW-1:0]         fe_kill;
    logic [FW-1:0][PW-1:0] fe_data;
    logic [NT-1:0] rs_set, rs_clr, xs_set, xs_clr, cs_set, cs_clr, c_sq, c_rob;
    logic [DW-1:0]         ren_vld;
    logic [DW-1:0][TW-1:0] ren_tid;
    logic [DW-1:0][PW-1:0] ren_data;
    logic [NT-1:0]         fe_block, fe_unblock;
    logic [NT-1:0][CW-1:0] sq_count;
    logic                  stage_active;

    decode_stall_ctl #(.NT(NT), .FW(FW), .DW(DW), .PW(PW), .FETCH_DLY(FD)) uut (
        .clk(clk), .rst_n(rst_n),
        .fe_vld(fe_vld), .fe_tid(fe_tid), .fe_kill(fe_kill), .fe_data(fe_data),
        .ren_stall_set(rs_set), .ren_stall_clr(rs_clr),
        .ex_stall_set(xs_set), .ex_stall_clr(xs_clr),
        .cmt_stall_set(cs_set), .cmt_stall_clr(cs_clr),
        .cmt_squash(c_sq), .cmt_rob_busy(c_rob),
        .ren_vld(ren_vld), .ren_tid(ren_tid), .ren_data(ren_data),
        .fe_block(fe_block), .fe_unblock(fe_unblock),
        .sq_count(sq_count), .stage_active(stage_active)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference: 0 idle, 1 run, 2 blocked, 3 unblock, 4 squash
    int mst [NT];
    bit fr [NT], fx [NT], fc [NT];
    logic [PW-1:0] mq [NT][$];
    int exp_n;
    int exp_tid [DW];
    int exp_dat [DW];
    bit exp_blk [NT], exp_unb [NT], exp_act;
    int exp_sq [NT];
    int dseq = 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s (phase %s) actual=%0d expected=%0d", req, phase, act, expv);
        end
    endtask

    task automatic model_step();
        int free, allc, k;
        bit stl;
        logic [PW-1:0] inq [$];
        exp_act = 0;
        for (int t = 0; t < NT; t++) if (mst[t] == 3) exp_act = 1;
        exp_n = 0;
        for (int j = 0; j < DW; j++) begin exp_tid[j] = 0; exp_dat[j] = 0; end
        free = DW;
        for (int t = 0; t < NT; t++) begin
            exp_blk[t] = 0; exp_unb[t] = 0;
            fr[t] = (fr[t] | rs_set[t]) & ~rs_clr[t];
            fx[t] = (fx[t] | xs_set[t]) & ~xs_clr[t];
            fc[t] = (fc[t] | cs_set[t]) & ~cs_clr[t];
            stl = fr[t] | fx[t] | fc[t];
            inq.delete();
            allc = 0;
            for (int s = 0; s < FW; s++)
                if (fe_vld[s] && int'(fe_tid[s]) == t) begin
                    allc++;
                    if (!fe_kill[s]) inq.push_back(fe_data[s]);
                end
            exp_sq[t] = c_sq[t] ? allc : 0;
            if (c_sq[t]) begin
                if (mst[t] == 2 || mst[t] == 3) exp_unb[t] = !(stl && mst[t] == 3);
                mst[t] = 4;
                mq[t].delete();
            end else if (c_rob[t]) begin
                mst[t] = 4;
            end else begin
                foreach (inq[i]) mq[t].push_back(inq[i]);
                if (stl) begin
                    exp_blk[t] = (mst[t] != 2);
                    mst[t] = 2;
                end else begin
                    k = (free < mq[t].size()) ? free : mq[t].size();
                    for (int i = 0; i < k; i++) begin
                        exp_tid[exp_n] = t;
                        exp_dat[exp_n] = int'(mq[t].pop_front());
                        exp_n++;
                    end
                    free -= k;
                    if (mst[t] == 2 || mst[t] == 3) begin
                        if (mq[t].size() == 0) begin mst[t] = 1; exp_unb[t] = 1; end
                        else mst[t] = 3;
                    end else if (mq[t].size() > 0) begin
                        mst[t] = 2; exp_blk[t] = 1;
                    end else if (!(mst[t] == 0 && k == 0)) begin
                        mst[t] = 1;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        for (int j = 0; j < DW; j++) begin
            check(ren_vld[j] == (j < exp_n), "R4 ren_vld", int'(ren_vld[j]), int'(j < exp_n));
            if (j < exp_n && ren_vld[j]) begin
                check(int'(ren_tid[j]) == exp_tid[j], "R4 ren_tid", int'(ren_tid[j]), exp_tid[j]);
                check(int'(ren_data[j]) == exp_dat[j], "R10 ren_data", int'(ren_data[j]), exp_dat[j]);
            end
        end
        for (int t = 0; t < NT; t++) begin
            check(fe_block[t] == exp_blk[t], "R3 fe_block", int'(fe_block[t]), int'(exp_blk[t]));
            check(fe_unblock[t] == exp_unb[t], "R5 fe_unblock", int'(fe_unblock[t]), int'(exp_unb[t]));
            check(int'(sq_count[t]) == exp_sq[t], "R6 sq_count", int'(sq_count[t]), exp_sq[t]);
        end
        check(stage_active == exp_act, "R11 stage_active", int'(stage_active), int'(exp_act));
    endtask

    task automatic clr();
        fe_vld = '0; fe_tid = '0; fe_kill = '0; fe_data = '0;
        rs_set = '0; rs_clr = '0; xs_set = '0; xs_clr = '0;
        cs_set = '0; cs_clr = '0; c_sq = '0; c_rob = '0;
    endtask

    task automatic put(input int s, input int t, input bit kill);
        fe_vld[s]  = 1'b1;
        fe_tid[s]  = TW'(t);
        fe_kill[s] = kill;
        fe_data[s] = PW'(dseq);
        dseq = (dseq % 250) + 1;
    endtask

    // inputs set after a falling edge; outputs sampled 1 ns later
    task automatic tick();
        #1;
        model_step();
        compare();
        @(negedge clk);
        clr();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin mst[t] = 0; fr[t] = 0; fx[t] = 0; fc[t] = 0; end
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        phase = "R1"; tick();
        check(ren_vld == '0 && fe_block == '0 && stage_active == 1'b0, "R1 reset", int'(ren_vld), 0);

        // R9: idle thread starts on first instruction; R4 ordering across threads
        phase = "R9"; put(0, 0, 0); put(1, 0, 0); tick();
        phase = "R4"; put(0, 1, 0); put(1, 0, 0); tick();
        // R10: killed slot dropped
        phase = "R10"; put(0, 0, 1); put(1, 1, 0); tick();

        // R2 / R3: sticky flags from two sources
        phase = "R3"; rs_set[0] = 1; put(0, 0, 0); put(1, 0, 0); tick();
        phase = "R2"; xs_set[0] = 1; put(0, 0, 0); put(1, 0, 0); tick();
        phase = "R2"; rs_clr[0] = 1; tick();
        phase = "R5"; xs_clr[0] = 1; tick();
        // R11 / R4: thread 0 drains, thread 1 overruns its share
        phase = "R11"; put(0, 1, 0); put(1, 1, 0); tick();
        phase = "R5"; tick();
        phase = "R2"; cs_set[1] = 1; cs_clr[1] = 1; put(0, 1, 0); tick();

        // R7: flush in BLOCKED sends unblock; R6 counts killed too
        phase = "R7"; cs_set[0] = 1; put(0, 0, 0); tick();
        phase = "R6"; c_sq[0] = 1; cs_clr[0] = 1; put(0, 0, 0); put(1, 0, 1); tick();
        phase = "R9"; tick();
        // R7: flush in UNBLOCK with a stall arriving cancels the block
        phase = "R7"; rs_set[0] = 1; put(0, 0, 0); put(1, 0, 0); tick();
        phase = "R7"; put(0, 0, 0); put(1, 0, 0); tick();
        phase = "R7"; rs_clr[0] = 1; tick();
        phase = "R7"; rs_set[0] = 1; c_sq[0] = 1; put(0, 0, 0); tick();
        phase = "R7"; rs_clr[0] = 1; tick();

        // R8: commit still flushing keeps thread 1 held
        phase = "R8"; c_rob[1] = 1; put(0, 1, 0); tick();
        phase = "R8"; c_rob[1] = 1; tick();
        phase = "R9"; put(0, 1, 0); tick();

        // R12: fill thread 1 skid queue to full depth, then drain
        phase = "R12"; rs_set[1] = 1; put(0, 1, 0); put(1, 1, 0); tick();
        phase = "R12"; put(0, 1, 0); put(1, 1, 0); tick();
        phase = "R12"; put(0, 1, 0); put(1, 1, 0); tick();
        phase = "R12"; rs_clr[1] = 1; tick();
        phase = "R12"; tick();
        phase = "R12"; tick();
        phase = "R12"; tick();

        // mixed traffic, fetch honouring the skid bound
        phase = "RND";
        for (int c = 0; c < 4000; c++) begin
            int used [NT];
            for (int t = 0; t < NT; t++) used[t] = 0;
            for (int s = 0; s < FW; s++) begin
                int t;
                t = $urandom_range(0, NT - 1);
                if ($urandom_range(0, 1) == 1 && mq[t].size() + used[t] < DEPTH) begin
                    put(s, t, $urandom_range(0, 9) == 0);
                    used[t]++;
                end
            end
            for (int t = 0; t < NT; t++) begin
                rs_set[t] = ($urandom_range(0, 19) == 0);
                xs_set[t] = ($urandom_range(0, 29) == 0);
                cs_set[t] = ($urandom_range(0, 39) == 0);
                rs_clr[t] = ($urandom_range(0, 5) == 0);
                xs_clr[t] = ($urandom_range(0, 5) == 0);
                cs_clr[t] = ($urandom_range(0, 5) == 0);
                c_sq[t]   = ($urandom_range(0, 39) == 0);
                c_rob[t]  = ($urandom_range(0, 39) == 0);
            end
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule